// File: doc/BRIEF.md
# Display Enable Timing Checker

This block watches the control side of a captured video stream, one sample per pixel clock: a data-enable line, horizontal and vertical sync, and a small group of general control bits. It measures every active period (enable high) and every blanking period (enable low). It also checks that the sync and control lines stay still around each enable transition.

Three kinds of fault are reported:
- a blanking period that is too short;
- an active period that runs too long;
- a sync or control change inside the guard window of an enable edge.

Each fault drives a one-cycle pulse and sets a flag that stays set until the clear input. Two length outputs give the most recently completed active period and the most recently completed blanking period, so a monitor can read the timing it is seeing.

The period that is under way when reset is released has no known start. It is left out of both the length checks and the length reporting. Measurement begins at the first enable edge after reset.

Top module: `de_timing_mon`

## Requirements
- R1: During and after reset, until the first violation, all flags and pulses are 0 and both length outputs are 0.
- R2: A blanking period shorter than MIN_BLANK (default 128) samples raises `blank_short_p`. Such a period is one whose enable-low samples are all followed by a rising enable. Exactly MIN_BLANK samples is legal.
- R3: An active period raises `active_long_p` once, on the sample that makes it MAX_ACTIVE+1 samples long (default 8192). A period of exactly MAX_ACTIVE samples is legal.
- R4: A change of any sync or control line on the sample where enable falls, or on the sample right after it, raises `sync_edge_p`. A change two samples after the fall does not.
- R5: A change of any sync or control line on the sample where enable rises raises `sync_edge_p`. A change one sample before the rise, or in the middle of a period, does not.
- R6: The period in progress when reset is released is neither length-checked nor reported.
- R7: On each rising edge, `last_blank_len` takes the length of the blanking period that just ended. On each falling edge, `last_active_len` takes the length of the active period that just ended. A length saturates at MAX_ACTIVE+1.
- R8: Each error flag is set by its pulse and holds until `clr` is sampled high. A pulse in the same cycle as `clr` leaves its flag set.
- R9: A pulse is high for exactly the one cycle that follows the clock edge that sampled the violating input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Clears the sticky error flags |
| de | input | 1 | Data enable, high in active video |
| hsync | input | 1 | Horizontal sync |
| vsync | input | 1 | Vertical sync |
| ctl | input | N_CTL | General control bits |
| blank_short_err | output | 1 | Sticky: blanking period too short |
| active_long_err | output | 1 | Sticky: active period too long |
| sync_edge_err | output | 1 | Sticky: sync/control change near an enable edge |
| blank_short_p | output | 1 | One-cycle pulse for a short blanking period |
| active_long_p | output | 1 | One-cycle pulse for an over-long active period |
| sync_edge_p | output | 1 | One-cycle pulse for a guarded sync/control change |
| last_active_len | output | CW | Length of the last completed active period |
| last_blank_len | output | CW | Length of the last completed blanking period |

## Verification
The period counter is the only long-lived state. If it is off by one or fails to restart, the error shows one enable edge later: the next length output is wrong, and a boundary length of MIN_BLANK or MAX_ACTIVE gives the wrong pulse decision. A wrong delayed copy of the enable or sync lines shows in the next cycle as a spurious or missing `sync_edge_p`. For that reason the bench places changes at the falling edge, one sample after it, two samples after it, one sample before the rise, and on the rise itself. A sticky flag that does not clear, or that loses a same-cycle pulse, shows on the flag outputs in the cycle after `clr`.

// File: rtl/de_timing_mon.sv
module de_timing_mon #(
  parameter int MIN_BLANK  = 128,
  parameter int MAX_ACTIVE = 8191,
  parameter int N_CTL      = 3,
  localparam int CW        = $clog2(MAX_ACTIVE + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             de,
  input  logic             hsync,
  input  logic             vsync,
  input  logic [N_CTL-1:0] ctl,
  output logic             blank_short_err,
  output logic             active_long_err,
  output logic             sync_edge_err,
  output logic             blank_short_p,
  output logic             active_long_p,
  output logic             sync_edge_p,
  output logic [CW-1:0]    last_active_len,
  output logic [CW-1:0]    last_blank_len
);
  localparam int SW = N_CTL + 2;
  localparam logic [CW-1:0] LEN_SAT = CW'(MAX_ACTIVE + 1);
  localparam logic [CW-1:0] LEN_MAX = CW'(MAX_ACTIVE);
  localparam logic [CW-1:0] LEN_MIN = CW'(MIN_BLANK);

  logic          started_q, known_q, de_q, fall_q;
  logic [SW-1:0] sync_q;
  logic [CW-1:0] run_q;

  wire [SW-1:0] sync_now = {ctl, vsync, hsync};
  wire rise      = started_q &  de & ~de_q;
  wire fall      = started_q & ~de &  de_q;
  wire blank_hit = rise & known_q & (run_q < LEN_MIN);
  wire long_hit  = started_q & de & de_q & known_q & (run_q == LEN_MAX);
  wire sync_hit  = started_q & (sync_now != sync_q) & (rise | fall | fall_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      started_q       <= 1'b0;
      known_q         <= 1'b0;
      de_q            <= 1'b0;
      fall_q          <= 1'b0;
      sync_q          <= '0;
      run_q           <= '0;
      last_active_len <= '0;
      last_blank_len  <= '0;
      blank_short_p   <= 1'b0;
      active_long_p   <= 1'b0;
      sync_edge_p     <= 1'b0;
      blank_short_err <= 1'b0;
      active_long_err <= 1'b0;
      sync_edge_err   <= 1'b0;
    end else begin
      started_q <= 1'b1;
      de_q      <= de;
      sync_q    <= sync_now;
      fall_q    <= fall;
      if (rise | fall) known_q <= 1'b1;
      if (rise | fall | !started_q) run_q <= CW'(1);
      else if (run_q != LEN_SAT)    run_q <= run_q + 1'b1;
      if (rise & known_q) last_blank_len  <= run_q;
      if (fall & known_q) last_active_len <= run_q;
      blank_short_p   <= blank_hit;
      active_long_p   <= long_hit;
      sync_edge_p     <= sync_hit;
      blank_short_err <= (blank_short_err & ~clr) | blank_hit;
      active_long_err <= (active_long_err & ~clr) | long_hit;
      sync_edge_err   <= (sync_edge_err   & ~clr) | sync_hit;
    end
  end
endmodule

// File: rtl/de_timing_mon_chk.sv
module de_timing_mon_chk #(
  parameter int MIN_BLANK  = 128,
  parameter int MAX_ACTIVE = 8191,
  parameter int N_CTL      = 3,
  localparam int CW        = $clog2(MAX_ACTIVE + 2)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr,
  input logic             de,
  input logic             hsync,
  input logic             vsync,
  input logic [N_CTL-1:0] ctl,
  input logic             blank_short_err,
  input logic             active_long_err,
  input logic             sync_edge_err,
  input logic             blank_short_p,
  input logic             active_long_p,
  input logic             sync_edge_p,
  input logic [CW-1:0]    last_active_len,
  input logic [CW-1:0]    last_blank_len
);
  // R8
  pulse_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_short_p |-> blank_short_err) and (active_long_p |-> active_long_err)
    and (sync_edge_p |-> sync_edge_err));

  // R8
  clear_drops_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> ((!blank_short_err || blank_short_p) && (!active_long_err || active_long_p)
             && (!sync_edge_err || sync_edge_p)));

  // R2
  short_blank_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blank_short_p |-> ($past(de) && (int'(last_blank_len) < MIN_BLANK)));

  // R3
  long_active_de_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_long_p |-> ($past(de) && $past(de, 2)));

  // R7
  blank_len_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last_blank_len != $past(last_blank_len)) |-> $past(de));

  // R7
  active_len_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last_active_len != $past(last_active_len)) |-> !$past(de));

  // R4
  sync_change_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_edge_p |-> ({$past(ctl), $past(vsync), $past(hsync)} !=
                     {$past(ctl, 2), $past(vsync, 2), $past(hsync, 2)}));
endmodule

bind de_timing_mon de_timing_mon_chk #(
  .MIN_BLANK(MIN_BLANK), .MAX_ACTIVE(MAX_ACTIVE), .N_CTL(N_CTL)
) u_chk (.*);

// File: tb/test_de_timing_mon.sv
module test_de_timing_mon;
  localparam int CW = $clog2(8191 + 2);

  logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0, de = 1'b0, hsync = 1'b0, vsync = 1'b0;
  logic [2:0] ctl = '0;
  logic blank_short_err, active_long_err, sync_edge_err;
  logic blank_short_p, active_long_p, sync_edge_p;
  logic [CW-1:0] last_active_len, last_blank_len;

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct { logic [2:0] p; string tag; } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;

  de_timing_mon i_de_timing_mon (.*);

  // Pulse bits in the scoreboard: {sync_edge_p, active_long_p, blank_short_p}
  always @(posedge clk) begin
    #5;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if ({sync_edge_p, active_long_p, blank_short_p} !== e.p) begin
        errors++;
        $display("FAIL %s pulses actual %b expected %b", e.tag,
                 {sync_edge_p, active_long_p, blank_short_p}, e.p);
      end
    end
  end

  task automatic drive(input logic d, input logic [4:0] s, input logic [2:0] e,
                       input logic c, input string tag);
    exp_t x;
    @(negedge clk);
    de = d; {ctl, vsync, hsync} = s; clr = c;
    x.p = e; x.tag = tag;
    q.push_back(x);
  endtask

  task automatic run(input logic d, input int n, input logic [4:0] s, input logic [2:0] e0,
                     input int idx, input logic [2:0] ei, input string tag);
    for (int k = 0; k < n; k++)
      drive(d, s, (k == 0) ? e0 : ((k == idx) ? ei : 3'b000), 1'b0, tag);
  endtask

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic settle;
    @(posedge clk); #2;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(int'({blank_short_err, active_long_err, sync_edge_err, blank_short_p,
              active_long_p, sync_edge_p}), 0, "R1 flags in reset");
    chk(int'(last_active_len) + int'(last_blank_len), 0, "R1 lengths in reset");
    rst_n = 1'b1;

    run(0, 10, 5'd0, 3'b000, -1, 3'b000, "R6 partial blank");
    run(1, 50, 5'd0, 3'b000, -1, 3'b000, "R6 first rise unchecked");
    settle();
    chk(int'(last_blank_len), 0, "R6 partial blank not reported");
    run(0, 5, 5'd0, 3'b000, -1, 3'b000, "R7 fall");
    run(1, 20, 5'd0, 3'b001, -1, 3'b000, "R2 short blank 5 R9");
    settle();
    chk(int'(last_active_len), 50, "R7 active length");
    chk(int'(last_blank_len), 5, "R7 blank length");
    chk(int'(blank_short_err), 1, "R8 sticky set");

    run(0, 60, 5'd0, 3'b000, -1, 3'b000, "R2 blank part");
    drive(0, 5'd0, 3'b000, 1'b1, "R8 clear cycle");
    run(0, 67, 5'd0, 3'b000, -1, 3'b000, "R2 blank part");
    chk(int'(blank_short_err), 0, "R8 cleared");
    run(1, 30, 5'd0, 3'b000, -1, 3'b000, "R2 blank exactly 128");
    settle();
    chk(int'(last_blank_len), 128, "R7 blank 128");
    run(0, 127, 5'd0, 3'b000, -1, 3'b000, "R2 blank");
    run(1, 30, 5'd0, 3'b001, -1, 3'b000, "R2 blank 127");

    run(0, 200, 5'd0, 3'b000, -1, 3'b000, "R3 blank");
    run(1, 8191, 5'd0, 3'b000, -1, 3'b000, "R3 active exactly max");
    run(0, 200, 5'd0, 3'b000, -1, 3'b000, "R3 fall after max");
    settle();
    chk(int'(last_active_len), 8191, "R3 active length 8191");
    chk(int'(active_long_err), 0, "R3 no flag at max");
    run(1, 8200, 5'd0, 3'b000, 8191, 3'b010, "R3 active too long");
    run(0, 200, 5'd0, 3'b000, -1, 3'b000, "R3 blank");
    settle();
    chk(int'(last_active_len), 8192, "R7 saturated length");
    chk(int'(active_long_err), 1, "R8 active flag");

    run(1, 50, 5'd0, 3'b000, -1, 3'b000, "R4 active");
    run(0, 200, 5'd1, 3'b100, -1, 3'b000, "R4 change on fall");
    run(1, 50, 5'd1, 3'b000, -1, 3'b000, "R4 active");
    run(0, 1, 5'd1, 3'b000, -1, 3'b000, "R4 fall");
    run(0, 200, 5'd2, 3'b100, -1, 3'b000, "R4 change one after fall");
    run(1, 50, 5'd2, 3'b000, -1, 3'b000, "R4 active");
    run(0, 2, 5'd2, 3'b000, -1, 3'b000, "R4 fall");
    run(0, 200, 5'd3, 3'b000, -1, 3'b000, "R4 change two after fall");
    run(0, 1, 5'd4, 3'b000, -1, 3'b000, "R5 change before rise");
    run(1, 50, 5'd4, 3'b000, -1, 3'b000, "R5 rise after settled");
    run(0, 200, 5'd4, 3'b000, -1, 3'b000, "R5 blank");
    run(1, 50, 5'd16, 3'b100, -1, 3'b000, "R5 ctl change on rise");
    run(0, 10, 5'd16, 3'b000, -1, 3'b000, "R5 short blank");
    run(1, 20, 5'd17, 3'b101, -1, 3'b000, "R2 R5 both on rise");
    run(1, 20, 5'd19, 3'b000, -1, 3'b000, "R5 mid active change");
    settle();
    chk(int'(sync_edge_err), 1, "R8 sync flag");

    repeat (3) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule